// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Access-Rights Checking

This block is a small, fully associative translation buffer. Each slot describes two neighbouring pages (an even page and an odd page) that share one virtual tag, one page-size mask and one address-space identifier. Each of the two pages has its own frame number and its own valid, dirty, no-execute and no-read bits.

A lookup is purely combinational. The caller presents a virtual address, the current address-space identifier and an access kind (fetch, load or store). In the same cycle the block returns a physical address and a small signed status code. The code is zero on success and a distinct negative value for each kind of fault. Slots are loaded through a synchronous write port, one slot per clock.

The block does no exception dispatch, no table walking and no victim selection. Those belong to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: After reset no slot is occupied, so every lookup returns code -2 with a physical address of zero until a slot has been written.
- R2: A slot hits when the virtual address bits not covered by its mask equal its tag, and either its global flag is set or its identifier equals `asid_i`. When no slot hits, the code is -2.
- R3: Within a hit slot, the address bit at the highest set bit of the slot's mask picks the page: 0 selects the even word (`wr_lo0_i`) and 1 selects the odd word (`wr_lo1_i`).
- R4: If the selected page's valid bit is clear, the code is -3 for every access kind. This check takes precedence over all the other rights checks.
- R5: A fetch (`acc_i` = 2'b00) to a valid page whose no-execute bit is set returns -6. The no-read bit has no effect on a fetch.
- R6: A load (`acc_i` = 2'b01) to a valid page whose no-read bit is set returns -5, even when execution is allowed. The no-execute bit has no effect on a load.
- R7: A store (`acc_i` = 2'b10) to a valid page whose dirty bit is clear returns -4. Neither inhibit bit has any effect on a store.
- R8: A lookup that passes every check returns code 0. Its physical address is the page's frame number shifted left by 12, with the page-offset bits (mask shifted right by one) taken from the virtual address.
- R9: Whenever the code is not 0, the physical address output is 0.
- R10: When several slots hit, the lowest-indexed one is used.
- R11: The page words are laid out as follows: bit 31 is no-read, bit 30 is no-execute, bits 25:6 are the frame number, bit 2 is dirty and bit 1 is valid. A write with `wr_en_i` high stores the mask, tag, identifier, global flag and both page words into slot `wr_idx_i` at the rising clock edge.
- R12: The access code 2'b11 is treated exactly as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the write port |
| rst_ni | input | 1 | Asynchronous active-low reset, clears slot occupancy |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 3 | Slot index to write |
| wr_mask_i | input | 32 | Pair mask (offset bits plus the even/odd bit set) |
| wr_tag_i | input | 32 | Virtual tag (bits above the mask are compared) |
| wr_asid_i | input | 8 | Address-space identifier of the slot |
| wr_global_i | input | 1 | Slot matches any identifier |
| wr_lo0_i | input | 32 | Even page word |
| wr_lo1_i | input | 32 | Odd page word |
| va_i | input | 32 | Lookup virtual address |
| asid_i | input | 8 | Current address-space identifier |
| acc_i | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| res_o | output | 4 | Signed status: 0, -2, -3, -4, -5, -6 |
| pa_o | output | 32 | Physical address, zero on a fault |

## Verification
The bench loads five slots: a 4 KB pair with mixed rights, a global pair with one invalid half, a 2 MB pair, a duplicate of the first slot, and a pair with both inhibit bits set. It then tries every access kind against each page. These patterns separate the precedence of invalid over the inhibit bits, the even/odd choice for small and large masks, identifier mismatch versus the global flag, and which inhibit bit each access kind honours. Directed cases cover the empty state after reset, a mid-run reset, and overwriting the lowest duplicate slot so that the next duplicate takes over.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  localparam logic signed [3:0] RES_OK      = 4'sd0;
  localparam logic signed [3:0] RES_NOMATCH = -4'sd2;
  localparam logic signed [3:0] RES_INVALID = -4'sd3;
  localparam logic signed [3:0] RES_DIRTY   = -4'sd4;
  localparam logic signed [3:0] RES_NOREAD  = -4'sd5;
  localparam logic signed [3:0] RES_NOEXEC  = -4'sd6;

  // page word field positions shared by the rights check
  localparam int unsigned VLD_BIT = 1;
  localparam int unsigned DRT_BIT = 2;
  localparam int unsigned FN_LSB  = 6;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int unsigned N      = 8,
  parameter int unsigned VA_W   = 32,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned LO_W   = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [VA_W-1:0]             wr_mask_i,
  input  logic [VA_W-1:0]             wr_tag_i,
  input  logic [ASID_W-1:0]           wr_asid_i,
  input  logic                        wr_global_i,
  input  logic [LO_W-1:0]             wr_lo0_i,
  input  logic [LO_W-1:0]             wr_lo1_i,
  input  logic [VA_W-1:0]             va_i,
  input  logic [ASID_W-1:0]           asid_i,
  output logic [N-1:0]                hit_o,
  output logic [N-1:0][VA_W-1:0]      mask_o,
  output logic [N-1:0][LO_W-1:0]      lo0_o,
  output logic [N-1:0][LO_W-1:0]      lo1_o
);
  logic [N-1:0]             occ_q;
  logic [N-1:0]             glb_q;
  logic [N-1:0][VA_W-1:0]   tag_q;
  logic [N-1:0][ASID_W-1:0] asid_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_q[g]  <= 1'b0;
        glb_q[g]  <= 1'b0;
        tag_q[g]  <= '0;
        asid_q[g] <= '0;
        mask_o[g] <= '0;
        lo0_o[g]  <= '0;
        lo1_o[g]  <= '0;
      end else if (sel) begin
        occ_q[g]  <= 1'b1;
        glb_q[g]  <= wr_global_i;
        tag_q[g]  <= wr_tag_i;
        asid_q[g] <= wr_asid_i;
        mask_o[g] <= wr_mask_i;
        lo0_o[g]  <= wr_lo0_i;
        lo1_o[g]  <= wr_lo1_i;
      end
    end

    assign hit_o[g] = occ_q[g]
                    && (((va_i ^ tag_q[g]) & ~mask_o[g]) == '0)
                    && (glb_q[g] || (asid_q[g] == asid_i));
  end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int unsigned N    = 8,
  parameter int unsigned VA_W = 32,
  parameter int unsigned LO_W = 32
) (
  input  logic [N-1:0]           hit_i,
  input  logic [N-1:0][VA_W-1:0] mask_i,
  input  logic [N-1:0][LO_W-1:0] lo0_i,
  input  logic [N-1:0][LO_W-1:0] lo1_i,
  output logic                   any_o,
  output logic [VA_W-1:0]        mask_o,
  output logic [LO_W-1:0]        lo0_o,
  output logic [LO_W-1:0]        lo1_o
);
  // walk from the top so the lowest hit index is written last
  always_comb begin
    any_o  = |hit_i;
    mask_o = '0;
    lo0_o  = '0;
    lo1_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        mask_o = mask_i[i];
        lo0_o  = lo0_i[i];
        lo1_o  = lo1_i[i];
      end
    end
  end
endmodule

// File: rtl/tlb_rights_check.sv
module tlb_rights_check
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned LO_W     = 32,
  parameter int unsigned FN_W     = 20,
  parameter int unsigned PG_SHIFT = 12,
  localparam int unsigned PA_W    = FN_W + PG_SHIFT,
  localparam int unsigned NR_BIT  = LO_W - 1,
  localparam int unsigned NX_BIT  = LO_W - 2
) (
  input  logic                   any_i,
  input  logic [VA_W-1:0]        mask_i,
  input  logic [LO_W-1:0]        lo0_i,
  input  logic [LO_W-1:0]        lo1_i,
  input  logic [VA_W-1:0]        va_i,
  input  logic [1:0]             acc_i,
  output logic signed [3:0]      res_o,
  output logic [PA_W-1:0]        pa_o
);
  logic [VA_W-1:0] off_mask;
  logic            odd;
  logic [LO_W-1:0] pg;
  logic [FN_W-1:0] fn;
  logic [PA_W-1:0] base;
  logic [PA_W-1:0] off_pa;
  logic [PA_W-1:0] va_pa;

  assign off_mask = mask_i >> 1;
  assign odd      = |(va_i & mask_i & ~off_mask);
  assign pg       = odd ? lo1_i : lo0_i;
  assign fn       = pg[FN_LSB +: FN_W];
  assign base     = {fn, {PG_SHIFT{1'b0}}};
  assign off_pa   = PA_W'(off_mask);
  assign va_pa    = PA_W'(va_i);

  always_comb begin
    if (!any_i)
      res_o = RES_NOMATCH;
    else if (!pg[VLD_BIT])
      res_o = RES_INVALID;
    else if (acc_i == ACC_FETCH && pg[NX_BIT])
      res_o = RES_NOEXEC;
    else if ((acc_i == ACC_LOAD || acc_i == ACC_LOAD2) && pg[NR_BIT])
      res_o = RES_NOREAD;
    else if (acc_i == ACC_STORE && !pg[DRT_BIT])
      res_o = RES_DIRTY;
    else
      res_o = RES_OK;
  end

  assign pa_o = (res_o == RES_OK) ? ((base & ~off_pa) | (va_pa & off_pa)) : '0;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int unsigned N        = 8,
  parameter int unsigned VA_W     = 32,
  parameter int unsigned ASID_W   = 8,
  parameter int unsigned LO_W     = 32,
  parameter int unsigned FN_W     = 20,
  parameter int unsigned PG_SHIFT = 12,
  localparam int unsigned IDX_W   = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned PA_W    = FN_W + PG_SHIFT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [VA_W-1:0]       wr_mask_i,
  input  logic [VA_W-1:0]       wr_tag_i,
  input  logic [ASID_W-1:0]     wr_asid_i,
  input  logic                  wr_global_i,
  input  logic [LO_W-1:0]       wr_lo0_i,
  input  logic [LO_W-1:0]       wr_lo1_i,
  input  logic [VA_W-1:0]       va_i,
  input  logic [ASID_W-1:0]     asid_i,
  input  logic [1:0]            acc_i,
  output logic signed [3:0]     res_o,
  output logic [PA_W-1:0]       pa_o
);
  logic [N-1:0]           hit;
  logic [N-1:0][VA_W-1:0] mask_a;
  logic [N-1:0][LO_W-1:0] lo0_a;
  logic [N-1:0][LO_W-1:0] lo1_a;
  logic                   any;
  logic [VA_W-1:0]        sel_mask;
  logic [LO_W-1:0]        sel_lo0;
  logic [LO_W-1:0]        sel_lo1;

  tlb_entry_store #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W), .LO_W(LO_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_mask_i   (wr_mask_i),
    .wr_tag_i    (wr_tag_i),
    .wr_asid_i   (wr_asid_i),
    .wr_global_i (wr_global_i),
    .wr_lo0_i    (wr_lo0_i),
    .wr_lo1_i    (wr_lo1_i),
    .va_i        (va_i),
    .asid_i      (asid_i),
    .hit_o       (hit),
    .mask_o      (mask_a),
    .lo0_o       (lo0_a),
    .lo1_o       (lo1_a)
  );

  tlb_prio_sel #(.N(N), .VA_W(VA_W), .LO_W(LO_W)) u_sel (
    .hit_i  (hit),
    .mask_i (mask_a),
    .lo0_i  (lo0_a),
    .lo1_i  (lo1_a),
    .any_o  (any),
    .mask_o (sel_mask),
    .lo0_o  (sel_lo0),
    .lo1_o  (sel_lo1)
  );

  tlb_rights_check #(.VA_W(VA_W), .LO_W(LO_W), .FN_W(FN_W), .PG_SHIFT(PG_SHIFT)) u_chk_rights (
    .any_i  (any),
    .mask_i (sel_mask),
    .lo0_i  (sel_lo0),
    .lo1_i  (sel_lo1),
    .va_i   (va_i),
    .acc_i  (acc_i),
    .res_o  (res_o),
    .pa_o   (pa_o)
  );
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_SHIFT = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VA_W-1:0]   va_i,
  input logic [1:0]        acc_i,
  input logic signed [3:0] res_o,
  input logic [PA_W-1:0]   pa_o
);
  p_fault_pa_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o != 4'sd0) |-> (pa_o == '0));

  p_store_no_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == 2'b10) |-> (res_o != -4'sd5 && res_o != -4'sd6));

  p_fetch_codes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == 2'b00) |-> (res_o != -4'sd5 && res_o != -4'sd4));

  p_load_codes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i[0] == 1'b1) |-> (res_o != -4'sd6 && res_o != -4'sd4));

  p_offset_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == 4'sd0) |-> (pa_o[PG_SHIFT-1:0] == va_i[PG_SHIFT-1:0]));

  p_legal_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == 4'sd0) || (res_o <= -4'sd2 && res_o >= -4'sd6));
endmodule

bind tlb_lookup tlb_lookup_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_lookup_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .va_i   (va_i),
  .acc_i  (acc_i),
  .res_o  (res_o),
  .pa_o   (pa_o)
);

// File: tb/tlb_lookup_bench.sv
`timescale 1ns/1ps
module tlb_lookup_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [2:0]         wr_idx = '0;
  logic [31:0]        wr_mask = '0, wr_tag = '0, wr_lo0 = '0, wr_lo1 = '0;
  logic [7:0]         wr_asid = '0;
  logic               wr_glb = 1'b0;
  logic [31:0]        va = '0;
  logic [7:0]         asid = '0;
  logic [1:0]         acc = '0;
  logic signed [3:0]  res;
  logic [31:0]        pa;
  int                 n_run = 0, n_fail = 0;
  bit                 done = 1'b0;

  always #2 clk = ~clk;

  tlb_lookup u_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_mask_i(wr_mask), .wr_tag_i(wr_tag), .wr_asid_i(wr_asid),
    .wr_global_i(wr_glb), .wr_lo0_i(wr_lo0), .wr_lo1_i(wr_lo1),
    .va_i(va), .asid_i(asid), .acc_i(acc), .res_o(res), .pa_o(pa)
  );

  typedef struct packed {
    logic [31:0]       va;
    logic [7:0]        asid;
    logic [1:0]        acc;
    logic signed [3:0] res;
    logic [31:0]       pa;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{32'h0001_0123, 8'd5, 2'd1,  4'sd0, 32'h0010_0123, 8'd8},  // R8 even load, R10 slot 0 over 3
    '{32'h0001_0123, 8'd5, 2'd0,  4'sd0, 32'h0010_0123, 8'd10}, // R10 fetch
    '{32'h0001_0123, 8'd5, 2'd2,  4'sd0, 32'h0010_0123, 8'd11}, // R11 dirty at bit 2
    '{32'h0001_1456, 8'd5, 2'd1,  4'sd0, 32'h0020_0456, 8'd3},  // R3 odd half
    '{32'h0001_1456, 8'd5, 2'd0, -4'sd6, 32'h0,         8'd5},  // R5 no-execute bit 30
    '{32'h0001_1456, 8'd5, 2'd2, -4'sd4, 32'h0,         8'd7},  // R7 clean page, NX ignored
    '{32'h0001_0123, 8'd6, 2'd1, -4'sd2, 32'h0,         8'd2},  // R2 identifier mismatch
    '{32'h0002_0010, 8'd6, 2'd1, -4'sd5, 32'h0,         8'd6},  // R6 no-read, execute allowed
    '{32'h0002_0010, 8'd9, 2'd0,  4'sd0, 32'h0030_0010, 8'd5},  // R5 NR ignored on fetch, global
    '{32'h0002_0010, 8'd6, 2'd2,  4'sd0, 32'h0030_0010, 8'd7},  // R7 NR ignored on store
    '{32'h0002_1010, 8'd6, 2'd1, -4'sd3, 32'h0,         8'd4},  // R4 invalid odd
    '{32'h0002_1010, 8'd6, 2'd2, -4'sd3, 32'h0,         8'd4},  // R4
    '{32'h0002_1010, 8'd6, 2'd0, -4'sd3, 32'h0,         8'd4},  // R4
    '{32'h005A_BCDE, 8'd7, 2'd1,  4'sd0, 32'h011A_BCDE, 8'd8},  // R8 2 MB even
    '{32'h006A_BCDE, 8'd7, 2'd1,  4'sd0, 32'h012A_BCDE, 8'd3},  // R3 2 MB odd
    '{32'h0005_0000, 8'd5, 2'd0, -4'sd6, 32'h0,         8'd5},  // R5 both inhibits, fetch
    '{32'h0005_0000, 8'd5, 2'd1, -4'sd5, 32'h0,         8'd6},  // R6 both inhibits, load
    '{32'h0005_0000, 8'd5, 2'd2,  4'sd0, 32'h0040_0000, 8'd7},  // R7 both inhibits, store
    '{32'h0005_1008, 8'd5, 2'd1,  4'sd0, 32'h0040_1008, 8'd6},  // R6 NX ignored on load
    '{32'h0005_0000, 8'd5, 2'd3, -4'sd5, 32'h0,         8'd12}, // R12 code 11 as load
    '{32'h0005_1008, 8'd5, 2'd3,  4'sd0, 32'h0040_1008, 8'd12}, // R12
    '{32'h0009_0000, 8'd5, 2'd1, -4'sd2, 32'h0,         8'd2}   // R2 tag miss
  };

  task automatic check(input string tag, input logic signed [3:0] er, input logic [31:0] ep);
    n_run++;
    if (res !== er || pa !== ep) begin
      n_fail++;
      $display("FAIL %s: res=%0d pa=%h expected res=%0d pa=%h", tag, res, pa, er, ep);
    end
  endtask

  task automatic look(input logic [31:0] v, input logic [7:0] a, input logic [1:0] k);
    @(negedge clk);
    va = v; asid = a; acc = k;
    #1;
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] m, input logic [31:0] t,
                    input logic [7:0] a, input logic g, input logic [31:0] l0, input logic [31:0] l1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_mask = m; wr_tag = t; wr_asid = a; wr_glb = g;
    wr_lo0 = l0; wr_lo1 = l1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_slots();
    wr(3'd0, 32'h0000_1FFF, 32'h0001_0000, 8'd5, 1'b0, 32'h0000_4006, 32'h4000_8002);
    wr(3'd1, 32'h0000_1FFF, 32'h0002_0000, 8'd0, 1'b1, 32'h8000_C006, 32'h0000_C044);
    wr(3'd2, 32'h003F_FFFF, 32'h0040_0000, 8'd7, 1'b0, 32'h0004_0006, 32'h0004_8006);
    wr(3'd3, 32'h0000_1FFF, 32'h0001_0000, 8'd5, 1'b0, 32'h0001_DDC6, 32'h0001_DDC6);
    wr(3'd4, 32'h0000_1FFF, 32'h0005_0000, 8'd5, 1'b0, 32'hC001_0006, 32'h4001_0046);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1; look(32'h0, 8'd0, 2'd1);
    check("R1 reset, no slot", -4'sd2, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    look(32'h0, 8'd0, 2'd1);
    check("R1 empty after reset", -4'sd2, 32'h0);

    load_slots();
    for (int i = 0; i < NV; i++) begin
      look(VEC[i].va, VEC[i].asid, VEC[i].acc);
      n_run++;
      if (res !== VEC[i].res || pa !== VEC[i].pa) begin
        n_fail++;
        $display("FAIL vec %0d (R%0d): res=%0d pa=%h expected res=%0d pa=%h",
                 i, VEC[i].req, res, pa, VEC[i].res, VEC[i].pa);
      end
    end

    // R10: move slot 0 away, duplicate slot 3 now wins
    wr(3'd0, 32'h0000_1FFF, 32'h0001_0000, 8'd9, 1'b0, 32'h0000_4006, 32'h4000_8002);
    look(32'h0001_0123, 8'd5, 2'd1);
    check("R10 next duplicate", 4'sd0, 32'h0077_7123);
    // R11: rewrite with odd page valid-bit clear, even page no-read via bit 31
    wr(3'd3, 32'h0000_1FFF, 32'h0001_0000, 8'd5, 1'b0, 32'h8001_DDC6, 32'h0001_DDC4);
    look(32'h0001_0123, 8'd5, 2'd1);
    check("R11 bit 31 no-read", -4'sd5, 32'h0);
    look(32'h0001_1123, 8'd5, 2'd2);
    check("R11 bit 1 valid", -4'sd3, 32'h0);

    // R1: mid-run reset empties all slots
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(32'h0002_0010, 8'd6, 2'd0);
    check("R1 after mid-run reset", -4'sd2, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule